// File: doc/BRIEF.md
# Power-Controller Command Executor

This block carries out one command for a power-management controller. The command code, the argument count and the first four argument bytes arrive together with a start strobe. The block then works out the reply bytes and the reply length, and it may raise a shutdown or restart pulse. It also keeps a seconds clock and holds the peripheral-bus autopoll settings. For a peripheral-bus command it checks the lengths and then either issues a request descriptor or raises a failure reply event. Bytes past the fourth stay in the caller's buffer, and the bus transaction itself happens outside this block.

The seconds clock counts from the 1904 epoch and is carried most significant byte first. A one-cycle strobe on `sec_tick` advances it, and a set-clock command loads it. The sequencer has three states. `ST_IDLE` goes to `ST_EXEC` when start is seen. `ST_EXEC` goes to `ST_DONE` unconditionally, and in that step every result is registered. `ST_DONE` goes back to `ST_IDLE` unconditionally while `done` is high.

Top module: `pm_cmd_engine`

## Requirements
- R1: A start seen in `ST_IDLE` gives `done` high for exactly one cycle, two clock edges after the edge that sampled start. `busy` is high in between. A start that arrives while `busy` is high is ignored.
- R2: After reset, a get-clock returns UNIX_INIT + 2082844800. At reset, `poll_en`, `poll_mask`, `done`, `rsp_len` and every event pulse are zero.
- R3: Get-clock (code 0x10) with count 0 returns 4 bytes: the counter's bits 31:24 in byte 0 down to bits 7:0 in byte 3. Byte i sits at `rsp_bytes[8i+7:8i]`. Any other count returns length 0. Each `sec_tick` cycle adds one, and the counter wraps modulo 2^32.
- R4: Set-clock (code 0x11) with count 4 loads {byte0,byte1,byte2,byte3} into the counter, byte 0 most significant. Any other count leaves the counter unchanged. The reply length is 0.
- R5: Shutdown (code 0x20) with count 4 returns one byte 0x00. It pulses `shutdown_req` only when bytes 0..3 are 0x4D 0x41 0x54 0x54. Any other count returns length 0 and gives no pulse.
- R6: Restart (code 0x21) with count 0 pulses `reset_req`. Any other count gives no pulse. The reply length is 0.
- R7: Code 0x30 returns one byte 0x01, code 0x31 returns one byte 0x00, and code 0x32 returns one byte 0x62, whatever the count.
- R8: A bus command (code 0x40) whose bytes 0,1 are 0x00,0x86 is an autopoll setting. With count 4 and mask = {byte2,byte3} nonzero, it stores the mask and sets `poll_en`. A zero mask clears `poll_en` and keeps the stored mask. A count other than 4 changes nothing. This form never gives a request or an error.
- R9: Other bus commands with count below 2 are ignored. A data length (byte 2) plus 3 greater than the count, or a data length above 252, pulses `bus_err_evt`. Otherwise `bus_req_valid` pulses with `bus_req_hdr` = byte 0 and `bus_req_nbytes` = count - 2.
- R10: Any other code returns zero bytes of length code[1:0] when code[7] is 0, and length 0 when code[7] is 1.
- R11: Reply bytes at and above `rsp_len` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Command strobe |
| op | input | 8 | Command code |
| arg_cnt | input | 8 | Argument byte count |
| arg_bytes | input | 32 | Argument bytes 0..3, byte i at [8i+7:8i] |
| sec_tick | input | 1 | One-second strobe |
| busy | output | 1 | Command in progress |
| done | output | 1 | Reply valid, one cycle |
| rsp_len | output | LEN_W | Reply length in bytes |
| rsp_bytes | output | RSP_MAX*8 | Reply bytes, byte i at [8i+7:8i] |
| shutdown_req | output | 1 | Shutdown pulse |
| reset_req | output | 1 | Restart pulse |
| poll_mask | output | 16 | Autopoll device mask |
| poll_en | output | 1 | Autopoll enabled |
| bus_req_valid | output | 1 | Bus request descriptor valid pulse |
| bus_req_hdr | output | 8 | Bus request header byte |
| bus_req_nbytes | output | 8 | Bytes to send: header plus data |
| bus_err_evt | output | 1 | Bus reply event with failure status |

## Verification
The bench builds the block with RSP_MAX = 4, so the reply field is exactly as wide as the clock reply. With UNIX_INIT = 0, the value read after reset is the bare epoch offset 0x7C25B080, which makes the offset itself observable. The bench loads 0xFFFFFFFF and then ticks once, which reaches the wrap of the 32-bit counter. The 8-bit count lets bus lengths at the count boundary be tried from both sides.

// File: rtl/pm_cmd_pkg.sv
package pm_cmd_pkg;
    localparam logic [7:0] OP_CLK_GET  = 8'h10;
    localparam logic [7:0] OP_CLK_SET  = 8'h11;
    localparam logic [7:0] OP_HALT     = 8'h20;
    localparam logic [7:0] OP_RESTART  = 8'h21;
    localparam logic [7:0] OP_VERSION  = 8'h30;
    localparam logic [7:0] OP_COVER    = 8'h31;
    localparam logic [7:0] OP_DLSTAT   = 8'h32;
    localparam logic [7:0] OP_BUS      = 8'h40;

    localparam int          HDR_BYTES   = 4;
    localparam logic [31:0] EPOCH_SHIFT = 32'd2082844800;
    localparam logic [31:0] HALT_SIG    = 32'h4D41_5454;
    localparam logic [7:0]  POLL_KEY0   = 8'h00;
    localparam logic [7:0]  POLL_KEY1   = 8'h86;
    localparam logic [8:0]  BUS_DLEN_MAX = 9'd252;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_EXEC = 2'd1,
        ST_DONE = 2'd2
    } seq_state_t;
endpackage

// File: rtl/pm_rtc_counter.sv
module pm_rtc_counter #(
    parameter logic [31:0] UNIX_INIT = 32'd0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick,
    input  logic        load,
    input  logic [31:0] load_val,
    output logic [31:0] secs
);
    import pm_cmd_pkg::*;

    localparam logic [31:0] INIT_VAL = UNIX_INIT + EPOCH_SHIFT;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     secs <= INIT_VAL;
        else if (load)  secs <= load_val;
        else if (tick)  secs <= secs + 32'd1;
    end

    p_tick_inc_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load) |=> (secs == $past(secs) + 32'd1));
    p_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (secs == $past(load_val)));
endmodule

// File: rtl/pm_bus_fmt.sv
module pm_bus_fmt (
    input  logic        is_bus,
    input  logic [7:0]  cnt,
    input  logic [7:0]  a0,
    input  logic [7:0]  a1,
    input  logic [7:0]  a2,
    input  logic [7:0]  a3,
    output logic        poll_set,
    output logic        poll_clr,
    output logic [15:0] poll_val,
    output logic        req_ok,
    output logic        req_err,
    output logic [7:0]  req_nbytes
);
    import pm_cmd_pkg::*;

    logic long_enough;
    logic poll_form;
    logic len_bad;

    always_comb begin
        long_enough = is_bus && (cnt >= 8'd2);
        poll_form   = long_enough && (a0 == POLL_KEY0) && (a1 == POLL_KEY1);
        poll_val    = {a2, a3};
        poll_set    = poll_form && (cnt == 8'd4) && (poll_val != 16'd0);
        poll_clr    = poll_form && (cnt == 8'd4) && (poll_val == 16'd0);
        len_bad     = ({1'b0, a2} + 9'd3 > {1'b0, cnt}) || ({1'b0, a2} > BUS_DLEN_MAX);
        req_err     = long_enough && !poll_form && len_bad;
        req_ok      = long_enough && !poll_form && !len_bad;
        req_nbytes  = cnt - 8'd2;
    end
endmodule

// File: rtl/pm_rsp_gen.sv
module pm_rsp_gen #(
    parameter int RSP_MAX = 4,
    localparam int LEN_W  = $clog2(RSP_MAX + 1)
) (
    input  logic [7:0]           op,
    input  logic [7:0]           cnt,
    input  logic [31:0]          args,
    input  logic [31:0]          secs,
    output logic [LEN_W-1:0]     len,
    output logic [RSP_MAX*8-1:0] rsp,
    output logic                 halt,
    output logic                 restart,
    output logic                 rtc_load,
    output logic [31:0]          rtc_val
);
    import pm_cmd_pkg::*;

    logic [31:0] be_word;

    always_comb begin
        be_word  = {args[7:0], args[15:8], args[23:16], args[31:24]};
        len      = '0;
        rsp      = '0;
        halt     = 1'b0;
        restart  = 1'b0;
        rtc_load = 1'b0;
        rtc_val  = be_word;
        case (op)
            OP_CLK_GET: begin
                if (cnt == 8'd0) begin
                    len        = LEN_W'(4);
                    rsp[7:0]   = secs[31:24];
                    rsp[15:8]  = secs[23:16];
                    rsp[23:16] = secs[15:8];
                    rsp[31:24] = secs[7:0];
                end
            end
            OP_CLK_SET: rtc_load = (cnt == 8'd4);
            OP_HALT: begin
                if (cnt == 8'd4) begin
                    len  = LEN_W'(1);
                    halt = (be_word == HALT_SIG);
                end
            end
            OP_RESTART: restart = (cnt == 8'd0);
            OP_VERSION: begin
                len      = LEN_W'(1);
                rsp[7:0] = 8'h01;
            end
            OP_COVER:  len = LEN_W'(1);
            OP_DLSTAT: begin
                len      = LEN_W'(1);
                rsp[7:0] = 8'h62;
            end
            OP_BUS:    len = '0;
            default:   len = op[7] ? '0 : LEN_W'(op[1:0]);
        endcase
    end
endmodule

// File: rtl/pm_cmd_engine.sv
module pm_cmd_engine #(
    parameter int          RSP_MAX   = 4,
    parameter logic [31:0] UNIX_INIT = 32'd0,
    localparam int         LEN_W     = $clog2(RSP_MAX + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [7:0]           op,
    input  logic [7:0]           arg_cnt,
    input  logic [31:0]          arg_bytes,
    input  logic                 sec_tick,
    output logic                 busy,
    output logic                 done,
    output logic [LEN_W-1:0]     rsp_len,
    output logic [RSP_MAX*8-1:0] rsp_bytes,
    output logic                 shutdown_req,
    output logic                 reset_req,
    output logic [15:0]          poll_mask,
    output logic                 poll_en,
    output logic                 bus_req_valid,
    output logic [7:0]           bus_req_hdr,
    output logic [7:0]           bus_req_nbytes,
    output logic                 bus_err_evt
);
    import pm_cmd_pkg::*;

    seq_state_t state, nxt;
    logic [7:0]  op_q;
    logic [7:0]  cnt_q;
    logic [31:0] arg_q;
    logic        exec;

    logic [LEN_W-1:0]     g_len;
    logic [RSP_MAX*8-1:0] g_rsp;
    logic                 g_halt, g_restart, g_load;
    logic [31:0]          g_rtc_val, secs;
    logic                 b_set, b_clr, b_ok, b_err;
    logic [15:0]          b_mask;
    logic [7:0]           b_nbytes;

    // sequencer state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: nxt = start ? ST_EXEC : ST_IDLE;
            ST_EXEC: nxt = ST_DONE;
            ST_DONE: nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    assign exec = (state == ST_EXEC);
    assign busy = (state != ST_IDLE);
    assign done = (state == ST_DONE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q  <= '0;
            cnt_q <= '0;
            arg_q <= '0;
        end else if (state == ST_IDLE && start) begin
            op_q  <= op;
            cnt_q <= arg_cnt;
            arg_q <= arg_bytes;
        end
    end

    pm_rtc_counter #(.UNIX_INIT(UNIX_INIT)) u_rtc (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (sec_tick),
        .load     (exec && g_load),
        .load_val (g_rtc_val),
        .secs     (secs)
    );

    pm_rsp_gen #(.RSP_MAX(RSP_MAX)) u_rsp (
        .op       (op_q),
        .cnt      (cnt_q),
        .args     (arg_q),
        .secs     (secs),
        .len      (g_len),
        .rsp      (g_rsp),
        .halt     (g_halt),
        .restart  (g_restart),
        .rtc_load (g_load),
        .rtc_val  (g_rtc_val)
    );

    pm_bus_fmt u_bus (
        .is_bus     (op_q == OP_BUS),
        .cnt        (cnt_q),
        .a0         (arg_q[7:0]),
        .a1         (arg_q[15:8]),
        .a2         (arg_q[23:16]),
        .a3         (arg_q[31:24]),
        .poll_set   (b_set),
        .poll_clr   (b_clr),
        .poll_val   (b_mask),
        .req_ok     (b_ok),
        .req_err    (b_err),
        .req_nbytes (b_nbytes)
    );

    // result registers, written on the EXEC to DONE step
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_len        <= '0;
            rsp_bytes      <= '0;
            shutdown_req   <= 1'b0;
            reset_req      <= 1'b0;
            poll_mask      <= '0;
            poll_en        <= 1'b0;
            bus_req_valid  <= 1'b0;
            bus_req_hdr    <= '0;
            bus_req_nbytes <= '0;
            bus_err_evt    <= 1'b0;
        end else begin
            shutdown_req  <= exec && g_halt;
            reset_req     <= exec && g_restart;
            bus_req_valid <= exec && b_ok;
            bus_err_evt   <= exec && b_err;
            if (exec) begin
                rsp_len   <= g_len;
                rsp_bytes <= g_rsp;
                if (b_set) begin
                    poll_mask <= b_mask;
                    poll_en   <= 1'b1;
                end else if (b_clr) begin
                    poll_en   <= 1'b0;
                end
                if (b_ok) begin
                    bus_req_hdr    <= arg_q[7:0];
                    bus_req_nbytes <= b_nbytes;
                end
            end
        end
    end

    p_done_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> ##1 done);
    p_done_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_halt_in_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown_req |-> done);
    p_restart_in_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |-> done);
    p_poll_moves_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(poll_en) |-> done);
    p_bus_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_req_valid && bus_err_evt));
    p_len_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (rsp_len <= LEN_W'(RSP_MAX)));
endmodule

// File: tb/pm_cmd_engine_tb.sv
module pm_cmd_engine_tb;
    localparam int CLK_PERIOD = 10;
    localparam int RSP_MAX    = 4;
    localparam int LEN_W      = $clog2(RSP_MAX + 1);
    localparam int WD_CYCLES  = 20000;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 start = 1'b0;
    logic [7:0]           op = '0;
    logic [7:0]           arg_cnt = '0;
    logic [31:0]          arg_bytes = '0;
    logic                 sec_tick = 1'b0;
    logic                 busy, done;
    logic [LEN_W-1:0]     rsp_len;
    logic [RSP_MAX*8-1:0] rsp_bytes;
    logic                 shutdown_req, reset_req, poll_en;
    logic [15:0]          poll_mask;
    logic                 bus_req_valid, bus_err_evt;
    logic [7:0]           bus_req_hdr, bus_req_nbytes;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pm_cmd_engine #(.RSP_MAX(RSP_MAX), .UNIX_INIT(32'd0)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .arg_cnt(arg_cnt),
        .arg_bytes(arg_bytes), .sec_tick(sec_tick), .busy(busy), .done(done),
        .rsp_len(rsp_len), .rsp_bytes(rsp_bytes), .shutdown_req(shutdown_req),
        .reset_req(reset_req), .poll_mask(poll_mask), .poll_en(poll_en),
        .bus_req_valid(bus_req_valid), .bus_req_hdr(bus_req_hdr),
        .bus_req_nbytes(bus_req_nbytes), .bus_err_evt(bus_err_evt)
    );

    typedef struct packed {
        logic [7:0]  op;
        logic [7:0]  cnt;
        logic [31:0] args;
        logic [2:0]  len;
        logic [31:0] rsp;
        logic        shut;
        logic        rst;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{8'h30, 8'd0, 32'h0,         3'd1, 32'h01, 1'b0, 1'b0}, // R7 version
        '{8'h31, 8'd2, 32'hAAAA,      3'd1, 32'h00, 1'b0, 1'b0}, // R7 cover
        '{8'h32, 8'd0, 32'h0,         3'd1, 32'h62, 1'b0, 1'b0}, // R7 status
        '{8'h13, 8'd0, 32'h0,         3'd3, 32'h00, 1'b0, 1'b0}, // R10 R11
        '{8'h05, 8'd2, 32'hFFFF,      3'd1, 32'h00, 1'b0, 1'b0}, // R10
        '{8'h82, 8'd0, 32'h0,         3'd0, 32'h00, 1'b0, 1'b0}, // R10
        '{8'h20, 8'd4, 32'h5454414D,  3'd1, 32'h00, 1'b1, 1'b0}, // R5 good sig
        '{8'h20, 8'd4, 32'h5854414D,  3'd1, 32'h00, 1'b0, 1'b0}, // R5 bad sig
        '{8'h20, 8'd3, 32'h5454414D,  3'd0, 32'h00, 1'b0, 1'b0}, // R5 bad count
        '{8'h21, 8'd0, 32'h0,         3'd0, 32'h00, 1'b0, 1'b1}, // R6
        '{8'h21, 8'd1, 32'h0,         3'd0, 32'h00, 1'b0, 1'b0}, // R6 bad count
        '{8'h10, 8'd1, 32'h0,         3'd0, 32'h00, 1'b0, 1'b0}  // R3 bad count
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run(input logic [7:0] c, input logic [7:0] n, input logic [31:0] a);
        @(negedge clk);
        op = c; arg_cnt = n; arg_bytes = a; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R1 busy", busy, 1);
        @(negedge clk);
        check("R1 done", done, 1);
    endtask

    task automatic tick_once();
        @(negedge clk); sec_tick = 1'b1;
        @(negedge clk); sec_tick = 1'b0;
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R2 reset state
        check("R2 poll_en", poll_en, 0);
        check("R2 poll_mask", poll_mask, 0);
        check("R2 done", done, 0);
        check("R2 rsp_len", rsp_len, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 pulses", {shutdown_req, reset_req, bus_req_valid, bus_err_evt}, 0);
        run(8'h10, 8'd0, 32'h0);
        check("R2 epoch len", rsp_len, 4);
        check("R2 epoch value", rsp_bytes, 32'h80B0257C);

        for (int i = 0; i < NV; i++) begin
            run(VECS[i].op, VECS[i].cnt, VECS[i].args);
            check($sformatf("vec%0d len", i), rsp_len, VECS[i].len);
            check($sformatf("vec%0d rsp", i), rsp_bytes, VECS[i].rsp);
            check($sformatf("vec%0d shutdown", i), shutdown_req, VECS[i].shut);
            check($sformatf("vec%0d restart", i), reset_req, VECS[i].rst);
        end

        // R4 set-clock, R3 ticks and byte order
        run(8'h11, 8'd4, 32'h78563412);
        check("R4 set len", rsp_len, 0);
        tick_once(); tick_once(); tick_once();
        run(8'h10, 8'd0, 32'h0);
        check("R3 ticked value", rsp_bytes, 32'h7B563412);
        run(8'h11, 8'd3, 32'h44332211);
        run(8'h10, 8'd0, 32'h0);
        check("R4 bad count ignored", rsp_bytes, 32'h7B563412);
        run(8'h11, 8'd4, 32'hFFFFFFFF);
        tick_once();
        run(8'h10, 8'd0, 32'h0);
        check("R3 wrap", rsp_bytes, 32'h0);

        // R8 autopoll
        run(8'h40, 8'd4, 32'h34128600);
        check("R8 mask", poll_mask, 16'h1234);
        check("R8 enable", poll_en, 1);
        check("R8 no request", {bus_req_valid, bus_err_evt}, 0);
        run(8'h40, 8'd5, 32'h00008600);
        check("R8 bad count ignored", {poll_en, poll_mask}, {1'b1, 16'h1234});
        run(8'h40, 8'd4, 32'h00008600);
        check("R8 zero mask disable", {poll_en, poll_mask}, {1'b0, 16'h1234});

        // R9 bus request formatting
        run(8'h40, 8'd1, 32'h0);
        check("R9 short ignored", {bus_req_valid, bus_err_evt}, 0);
        run(8'h40, 8'd6, 32'h0003002C);
        check("R9 valid", {bus_req_valid, bus_err_evt}, 2'b10);
        check("R9 hdr", bus_req_hdr, 8'h2C);
        check("R9 nbytes", bus_req_nbytes, 8'd4);
        run(8'h40, 8'd5, 32'h0003002C);
        check("R9 len error", {bus_req_valid, bus_err_evt}, 2'b01);
        run(8'h40, 8'd2, 32'h0000002C);
        check("R9 count two error", {bus_req_valid, bus_err_evt}, 2'b01);

        // R1 start while busy ignored
        @(negedge clk);
        op = 8'h30; arg_cnt = 8'd0; start = 1'b1;
        @(negedge clk);
        @(negedge clk);
        start = 1'b0;
        check("R1 first done", done, 1);
        @(negedge clk);
        check("R1 no second done", done, 0);
        @(negedge clk);
        check("R1 idle", busy, 0);

        finished = 1;
        summary();
        $finish;
    end
endmodule